// File: doc/BRIEF.md
# Three-Step Block-Matching Search Controller

This block steers a three-step motion search for one macroblock. Starting from a seed position inside a square search window of ±`RANGE` pixels, it walks a nine-point pattern: the present centre plus the eight neighbours that lie one step away horizontally, vertically and diagonally. It sends each candidate displacement (u,v) to an external cost unit and receives back a sum of absolute differences (SAD). When a step is finished, the centre moves to the cheapest point and the step size halves. After three steps the final centre is the motion vector.

Pixel access and SAD arithmetic stay in the cost unit. This controller only orders the candidates, tracks the minimum and controls the step size. A search starts with a one-cycle `start` pulse. `busy` stays high until a one-cycle `done` pulse delivers the vector and its SAD.

States:
- `ST_IDLE` waits for `start`.
- `ST_SCAN` picks the next pattern index, or skips it.
- `ST_ISSUE` holds a request until `req_ready`.
- `ST_AWAIT` waits for `rsp_valid`.
- `ST_ADVANCE` moves the centre and halves the step.
- `ST_REPORT` pulses `done`.

Transitions:
- idle→scan on start.
- scan→scan on a skip.
- scan→issue for a live candidate.
- scan→advance after index 8.
- issue→await on ready.
- await→scan on response.
- advance→scan after the first two steps.
- advance→report after the third step.
- report→idle always.

Top module: `tss_search`

## Requirements
- R1: Within a step, candidates are visited in pattern index order 0..8. With step s, the offsets are: 0 = centre (0,0), 1 = (-s,-s), 2 = (0,-s), 3 = (+s,-s), 4 = (+s,0), 5 = (+s,+s), 6 = (0,+s), 7 = (-s,+s), 8 = (-s,0). Negative v is upward, so this is clockwise from the top-left.
- R2: At the end of each step, the centre moves to the candidate with the smallest SAD. A candidate replaces the running best only when its SAD is strictly lower. Ties therefore keep the centre, and among the other points the earliest in index order wins.
- R3: The first step uses s = RANGE/2. Each later step halves s. Exactly three steps run, and the centre after the third step is the reported vector.
- R4: In the second and third steps the centre is not requested again; its SAD is carried over from the step before. With no skipped points a search therefore issues exactly 9+8+8 = 25 requests.
- R5: A candidate with |u| > RANGE or |v| > RANGE is skipped and never appears on the request port.
- R6: `req_valid` stays high with `req_u`/`req_v` unchanged until `req_ready` is seen. No new request is raised between an accepted request and its `rsp_valid`.
- R7: `done` is high for exactly one cycle per search. It carries the signed final vector on `mv_u`/`mv_v` and its SAD on `mv_sad`.
- R8: After reset the block is idle: `busy`, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (taken when idle) |
| seed_u | input | MV_W | Signed starting horizontal position, inside the window |
| seed_v | input | MV_W | Signed starting vertical position, inside the window |
| busy | output | 1 | A search is in progress |
| req_valid | output | 1 | Candidate request valid |
| req_ready | input | 1 | Cost unit accepts the request |
| req_u | output | MV_W | Signed candidate horizontal displacement |
| req_v | output | MV_W | Signed candidate vertical displacement |
| rsp_valid | input | 1 | SAD response strobe |
| rsp_sad | input | SAD_W | SAD of the outstanding candidate |
| done | output | 1 | One-cycle result strobe |
| mv_u | output | MV_W | Signed final horizontal vector |
| mv_v | output | MV_W | Signed final vertical vector |
| mv_sad | output | SAD_W | SAD at the final vector |

## Verification
The hardest situation to reach is a step in which window skipping and centre reuse happen together, so that the request count drops below 25 while the minimum still has to come from the carried-over centre SAD. The stimulus reaches it by seeding the search close to a window corner with a cost surface whose minimum lies at that corner. A bench-side model of the pattern then predicts the exact pruned request list. Ready stalls and response latencies are varied so that the hold rules of the request port are exercised.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ISSUE,
        ST_AWAIT,
        ST_ADVANCE,
        ST_REPORT
    } tss_state_e;

    localparam int unsigned NUM_POINTS = 9;
    localparam int unsigned NUM_STEPS  = 3;
    localparam int unsigned IDX_W      = 4;

    // Horizontal direction of pattern index k: -1, 0 or +1
    function automatic logic signed [1:0] dir_u(input logic [IDX_W-1:0] k);
        logic signed [1:0] d;
        unique case (k)
            4'd1, 4'd7, 4'd8: d = -2'sd1;
            4'd3, 4'd4, 4'd5: d = 2'sd1;
            default:          d = 2'sd0;
        endcase
        return d;
    endfunction

    // Vertical direction of pattern index k (negative is up)
    function automatic logic signed [1:0] dir_v(input logic [IDX_W-1:0] k);
        logic signed [1:0] d;
        unique case (k)
            4'd1, 4'd2, 4'd3: d = -2'sd1;
            4'd5, 4'd6, 4'd7: d = 2'sd1;
            default:          d = 2'sd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tss_cand_gen.sv
module tss_cand_gen #(
    parameter int RANGE = 8,
    parameter int MV_W  = 6,
    parameter int ST_W  = 4
) (
    input  logic signed [MV_W-1:0]         ctr_u,
    input  logic signed [MV_W-1:0]         ctr_v,
    input  logic [ST_W-1:0]                step,
    input  logic [tss_pkg::IDX_W-1:0]      idx,
    output logic signed [MV_W-1:0]         cand_u,
    output logic signed [MV_W-1:0]         cand_v,
    output logic                           in_window
);
    localparam logic signed [MV_W-1:0] LIM = MV_W'(RANGE);

    logic signed [MV_W-1:0] step_s;
    logic signed [MV_W-1:0] ctr  [2];
    logic signed [MV_W-1:0] cand [2];
    logic signed [1:0]      dir  [2];
    logic [1:0]             axis_ok;

    assign step_s = MV_W'(step);
    assign ctr[0] = ctr_u;
    assign ctr[1] = ctr_v;
    assign dir[0] = tss_pkg::dir_u(idx);
    assign dir[1] = tss_pkg::dir_v(idx);

    for (genvar ax = 0; ax < 2; ax++) begin : g_axis
        logic signed [MV_W-1:0] offs;
        always_comb begin
            if (dir[ax] == 2'sd1)       offs = step_s;
            else if (dir[ax] == -2'sd1) offs = -step_s;
            else                        offs = '0;
        end
        assign cand[ax]    = ctr[ax] + offs;
        assign axis_ok[ax] = (cand[ax] <= LIM) && (cand[ax] >= -LIM);
    end

    assign cand_u    = cand[0];
    assign cand_v    = cand[1];
    assign in_window = &axis_ok;

endmodule

// File: rtl/tss_min_track.sv
module tss_min_track #(
    parameter int MV_W  = 6,
    parameter int SAD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_seed,
    input  logic signed [MV_W-1:0]  seed_u,
    input  logic signed [MV_W-1:0]  seed_v,
    input  logic                    take,
    input  logic                    force_take,
    input  logic signed [MV_W-1:0]  cand_u,
    input  logic signed [MV_W-1:0]  cand_v,
    input  logic [SAD_W-1:0]        sad,
    output logic signed [MV_W-1:0]  best_u,
    output logic signed [MV_W-1:0]  best_v,
    output logic [SAD_W-1:0]        best_sad
);
    logic better;

    // strict comparison: equal cost never displaces the incumbent
    assign better = force_take || (sad < best_sad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_u   <= '0;
            best_v   <= '0;
            best_sad <= '1;
        end else if (load_seed) begin
            best_u   <= seed_u;
            best_v   <= seed_v;
            best_sad <= '1;
        end else if (take && better) begin
            best_u   <= cand_u;
            best_v   <= cand_v;
            best_sad <= sad;
        end
    end

endmodule

// File: rtl/tss_search.sv
module tss_search #(
    parameter int RANGE = 8,
    parameter int MV_W  = 6,
    parameter int SAD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [MV_W-1:0]  seed_u,
    input  logic signed [MV_W-1:0]  seed_v,
    output logic                    busy,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic signed [MV_W-1:0]  req_u,
    output logic signed [MV_W-1:0]  req_v,
    input  logic                    rsp_valid,
    input  logic [SAD_W-1:0]        rsp_sad,
    output logic                    done,
    output logic signed [MV_W-1:0]  mv_u,
    output logic signed [MV_W-1:0]  mv_v,
    output logic [SAD_W-1:0]        mv_sad
);
    import tss_pkg::*;

    localparam int                  ST_W      = $clog2(RANGE) + 1;
    localparam logic [ST_W-1:0]     STEP0     = ST_W'(RANGE / 2);
    localparam logic [IDX_W-1:0]    IDX_END   = IDX_W'(NUM_POINTS);
    localparam logic [1:0]          LAST_STG  = 2'(NUM_STEPS - 1);

    tss_state_e state, nxt;

    logic [IDX_W-1:0]        idx_r;
    logic [ST_W-1:0]         step_r;
    logic [1:0]              stage_r;
    logic signed [MV_W-1:0]  ctr_u_r, ctr_v_r;
    logic signed [MV_W-1:0]  cand_u, cand_v;
    logic                    in_window;
    logic                    idx_done, skip;
    logic signed [MV_W-1:0]  best_u, best_v;
    logic [SAD_W-1:0]        best_sad;
    logic                    launch, resp_take;

    tss_cand_gen #(.RANGE(RANGE), .MV_W(MV_W), .ST_W(ST_W)) u_cand (
        .ctr_u     (ctr_u_r),
        .ctr_v     (ctr_v_r),
        .step      (step_r),
        .idx       (idx_r),
        .cand_u    (cand_u),
        .cand_v    (cand_v),
        .in_window (in_window)
    );

    assign launch    = (state == ST_IDLE) && start;
    assign resp_take = (state == ST_AWAIT) && rsp_valid;

    tss_min_track #(.MV_W(MV_W), .SAD_W(SAD_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_seed  (launch),
        .seed_u     (seed_u),
        .seed_v     (seed_v),
        .take       (resp_take),
        .force_take (idx_r == '0),
        .cand_u     (cand_u),
        .cand_v     (cand_v),
        .sad        (rsp_sad),
        .best_u     (best_u),
        .best_v     (best_v),
        .best_sad   (best_sad)
    );

    assign idx_done = (idx_r == IDX_END);
    assign skip     = !in_window || ((idx_r == '0) && (stage_r != '0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SCAN;
            ST_SCAN: begin
                if (idx_done)  nxt = ST_ADVANCE;
                else if (skip) nxt = ST_SCAN;
                else           nxt = ST_ISSUE;
            end
            ST_ISSUE:   if (req_ready) nxt = ST_AWAIT;
            ST_AWAIT:   if (rsp_valid) nxt = ST_SCAN;
            ST_ADVANCE: nxt = (stage_r == LAST_STG) ? ST_REPORT : ST_SCAN;
            ST_REPORT:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // search datapath: centre, step, stage, pattern index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_r   <= '0;
            step_r  <= '0;
            stage_r <= '0;
            ctr_u_r <= '0;
            ctr_v_r <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ctr_u_r <= seed_u;
                    ctr_v_r <= seed_v;
                    step_r  <= STEP0;
                    stage_r <= '0;
                    idx_r   <= '0;
                end
                ST_SCAN:  if (!idx_done && skip) idx_r <= idx_r + 1'b1;
                ST_AWAIT: if (rsp_valid)         idx_r <= idx_r + 1'b1;
                ST_ADVANCE: begin
                    ctr_u_r <= best_u;
                    ctr_v_r <= best_v;
                    step_r  <= step_r >> 1;
                    stage_r <= stage_r + 1'b1;
                    idx_r   <= '0;
                end
                default: ;
            endcase
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_u   <= '0;
            mv_v   <= '0;
            mv_sad <= '0;
        end else if ((state == ST_ADVANCE) && (stage_r == LAST_STG)) begin
            mv_u   <= best_u;
            mv_v   <= best_v;
            mv_sad <= best_sad;
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        req_valid = (state == ST_ISSUE);
        done      = (state == ST_REPORT);
        req_u     = cand_u;
        req_v     = cand_v;
    end

endmodule

// File: rtl/tss_search_chk.sv
module tss_search_chk #(
    parameter int RANGE = 8,
    parameter int MV_W  = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic signed [MV_W-1:0]  req_u,
    input logic signed [MV_W-1:0]  req_v,
    input logic                    rsp_valid,
    input logic                    done
);
    localparam logic signed [MV_W-1:0] LIM = MV_W'(RANGE);

    logic       pending;
    logic [5:0] fired;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            fired   <= '0;
        end else begin
            if (req_valid && req_ready) pending <= 1'b1;
            else if (rsp_valid)         pending <= 1'b0;
            if (start && !busy)              fired <= '0;
            else if (req_valid && req_ready) fired <= fired + 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_u) && $stable(req_v)); // R6

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !req_valid); // R6

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_u <= LIM) && (req_u >= -LIM) && (req_v <= LIM) && (req_v >= -LIM)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_REQ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fired <= 6'd25); // R4

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !pending); // R7

endmodule

bind tss_search tss_search_chk #(.RANGE(RANGE), .MV_W(MV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_u     (req_u),
    .req_v     (req_v),
    .rsp_valid (rsp_valid),
    .done      (done)
);

// File: tb/tss_search_tb.sv
`timescale 1ns/1ps
module tss_search_tb;
    localparam int RANGE = 8;
    localparam int MV_W  = 6;
    localparam int SAD_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [MV_W-1:0] seed_u = '0, seed_v = '0;
    logic busy, req_valid, done;
    logic req_ready = 1'b0;
    logic signed [MV_W-1:0] req_u, req_v, mv_u, mv_v;
    logic rsp_valid = 1'b0;
    logic [SAD_W-1:0] rsp_sad = '0;
    logic [SAD_W-1:0] mv_sad;

    always #2 clk = ~clk;

    tss_search #(.RANGE(RANGE), .MV_W(MV_W), .SAD_W(SAD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_u(seed_u), .seed_v(seed_v),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_u(req_u), .req_v(req_v), .rsp_valid(rsp_valid), .rsp_sad(rsp_sad),
        .done(done), .mv_u(mv_u), .mv_v(mv_v), .mv_sad(mv_sad)
    );

    int total = 0;
    int fails = 0;
    bit finished = 0;

    int cmode = 0, tgt_u = 0, tgt_v = 0, cconst = 0;
    int exp_u [32];
    int exp_v [32];
    int exp_n, exp_mu, exp_mv, exp_sad;
    int off_u [9] = '{0, -1, 0, 1, 1, 1, 0, -1, -1};
    int off_v [9] = '{0, -1, -1, -1, 0, 1, 1, 1, 0};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic int cost(input int u, input int v);
        if (cmode == 0)      return 3 * (iabs(u - tgt_u) + iabs(v - tgt_v)) + 1;
        else if (cmode == 1) return cconst;
        else                 return ((u + 16) * 37 + (v + 16) * 11) % 29;
    endfunction

    // independent model of the search, built from the requirements
    task automatic build_expect(input int su, input int sv);
        int cu, cv, st, bu, bv, bs;
        cu = su; cv = sv; st = RANGE / 2; bu = su; bv = sv; bs = 0;
        exp_n = 0;
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 9; k++) begin
                int pu, pv, c;
                pu = cu + off_u[k] * st;
                pv = cv + off_v[k] * st;
                if (!(k == 0 && s > 0) &&
                    !(pu > RANGE || pu < -RANGE || pv > RANGE || pv < -RANGE)) begin
                    exp_u[exp_n] = pu;
                    exp_v[exp_n] = pv;
                    exp_n++;
                    c = cost(pu, pv);
                    if (k == 0 || c < bs) begin
                        bs = c; bu = pu; bv = pv;
                    end
                end
            end
            cu = bu; cv = bv; st = st / 2;
        end
        exp_mu = bu; exp_mv = bv; exp_sad = bs;
    endtask

    task automatic run_case(input string name, input int su, input int sv,
                            input int max_dly, input int lat, input bit full);
        int n, seq_err, overlap, unstable, done_cnt, pulse_err, guard;
        int ru, rv, got_u, got_v, got_sad;
        build_expect(su, sv);
        n = 0; seq_err = 0; overlap = 0; unstable = 0; done_cnt = 0;
        pulse_err = 0; guard = 0; got_u = 0; got_v = 0; got_sad = 0;
        @(negedge clk);
        seed_u = MV_W'(su); seed_v = MV_W'(sv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cnt == 0 && guard < 3000) begin
            guard++;
            if (req_valid) begin
                int dly;
                ru = int'(req_u); rv = int'(req_v);
                dly = (n * 7 + su + 20) % (max_dly + 1);
                for (int w = 0; w < dly; w++) begin
                    @(negedge clk);
                    if (!req_valid || int'(req_u) != ru || int'(req_v) != rv) unstable++;
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                if (n >= 32 || n >= exp_n || exp_u[n] != ru || exp_v[n] != rv) seq_err++;
                n++;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    if (req_valid) overlap++;
                end
                if (req_valid) overlap++;
                rsp_valid = 1'b1;
                rsp_sad = SAD_W'(cost(ru, rv));
                @(negedge clk);
                rsp_valid = 1'b0;
            end else if (done) begin
                done_cnt++;
                got_u = int'(mv_u); got_v = int'(mv_v); got_sad = int'(mv_sad);
                @(negedge clk);
                if (done) pulse_err++;
            end else begin
                @(negedge clk);
            end
        end
        $display("case %s: %0d requests", name, n);
        check(seq_err == 0, "R1", {name, " candidate order/offsets"}, seq_err, 0);
        check(n == exp_n, "R5", {name, " request count after skips"}, n, exp_n);
        if (full) check(n == 25, "R4", {name, " centre reused, 25 requests"}, n, 25);
        check(got_u == exp_mu && got_v == exp_mv, "R2",
              {name, " final vector u*100+v"}, got_u * 100 + got_v, exp_mu * 100 + exp_mv);
        check(got_sad == exp_sad, "R3", {name, " final SAD after three steps"}, got_sad, exp_sad);
        check(overlap == 0 && unstable == 0, "R6", {name, " request hold / single outstanding"},
              overlap + unstable, 0);
        check(done_cnt == 1 && pulse_err == 0, "R7", {name, " one-cycle done"},
              done_cnt * 10 + pulse_err, 10);
        check(!busy, "R7", {name, " idle after done"}, busy, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!busy && !req_valid && !done, "R8", "reset state busy/req/done",
              {busy, req_valid, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R8", "idle after reset release",
              {busy, req_valid, done}, 0);

        // R2 R3: clear minimum far from seed
        cmode = 0; tgt_u = 3; tgt_v = -5;
        run_case("slope", 0, 0, 0, 0, 1'b1);

        // R2: flat surface, all ties keep the centre
        cmode = 1; cconst = 7;
        run_case("flat", 2, -1, 2, 1, 1'b1);
        check(exp_mu == 2 && exp_mv == -1, "R2", "model: ties stay on seed",
              exp_mu * 100 + exp_mv, 199);

        // R5: seed near corner, minimum at the corner
        cmode = 0; tgt_u = 8; tgt_v = 8;
        run_case("corner", 6, 7, 1, 2, 1'b0);
        check(exp_n < 25, "R5", "corner case prunes candidates", exp_n, 24);

        // R1 R2: irregular surface, stalls and latency
        cmode = 2;
        run_case("hash", -3, 2, 3, 2, 1'b1);

        // R3: minimum reachable only through all three step sizes
        cmode = 0; tgt_u = -7; tgt_v = 6;
        run_case("far", 0, 0, 1, 3, 1'b1);

        // R5: opposite corner
        cmode = 0; tgt_u = -8; tgt_v = -8;
        run_case("corner2", -8, -6, 2, 0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog R7: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule